// File: doc/BRIEF.md
# Infrared Receive Buffer with Interrupt Sources

This block sits between an infrared sampler and a host register port. The sampler hands it encoded run bytes, one per cycle when `smp_valid` is high, plus an end-of-packet pulse. The block queues the bytes in a first-in first-out store that holds 16 entries by default. The host reads the oldest byte through a data register, and each such read removes that byte. A status register reports how many bytes are waiting and carries three sticky event flags: overflow, packet end and data available. Each flag has its own enable, and `irq` is high while any enabled flag is set.

Intake is governed by a three-state machine with the states OFF, HOLD and RUN. A host write to the control register is the only event that moves it, and it follows the global-enable bit (bit 0) and the receive-enable bit (bit 1). A write with bit 1 low moves any state to OFF. A write with bit 1 high and bit 0 low moves any state to HOLD. A write with both bits high moves any state to RUN. In OFF the queue is emptied. In HOLD the queued bytes are kept but no new ones are taken in. In RUN sampler bytes and packet-end pulses are taken in.

Register map (byte addresses): 0x00 control, 0x10 receive configuration, 0x20 data, 0x2C interrupt enable, 0x30 status, 0x34 sample configuration. Reads are combinational from the current state. All updates happen on the rising clock edge.

Top module: `ir_rx_buffer`

## Requirements
- R1: The queue holds at most DEPTH (16) bytes. Status register 0x30 reports the number of waiting bytes in bits 13:8, and that number never exceeds DEPTH.
- R2: Reading address 0x20 shows the oldest byte in bits 7:0. When `reg_rd` is high, that byte is removed. An empty queue reads as 0, and a read of an empty queue changes nothing.
- R3: Bytes are taken in only in RUN (control bits 1 and 0 both 1). In HOLD (bit 1 = 1, bit 0 = 0) offered bytes are ignored and the queued bytes are kept.
- R4: Interrupt-enable register 0x2C holds the overflow enable at bit 0, the packet-end enable at bit 1, the data-available enable at bit 4, and a 4-bit level field at bits 11:8. All of these read back as written.
- R5: Status bit 4 (data available) is set on the clock edge that follows any cycle in which the count is greater than the level field. Because the condition is re-evaluated on every edge, a clear has no visible effect while the condition still holds.
- R6: A byte offered to a full queue in a cycle with no pop is dropped, the queued bytes stay as they were, and status bit 0 (overflow) is set. A pop and a push in the same cycle on a full queue drop nothing.
- R7: A packet-end pulse in RUN sets status bit 1. A packet-end pulse in any other state has no effect.
- R8: A write to 0x30 clears each flag whose bit in the written data is 1 and leaves the other flags unchanged, so writing 0xFF clears all flags. If a flag is set and cleared in the same cycle, the set wins.
- R9: `irq` is high exactly when at least one status flag is set together with its enable bit.
- R10: A control write with bit 1 = 0 enters OFF. One cycle later the queue is empty, and it stays empty while the block is in OFF.
- R11: Registers 0x10 and 0x34 read back as written and drive `cfg_rx` and `cfg_sample`. Control bits 5:4 read back as written. Control bit 0 reads back as written, and control bit 1 reads 1 in HOLD and RUN. Any other address reads 0, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; removes the oldest byte when the address is 0x20 |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| smp_valid | input | 1 | A sampler byte is offered this cycle |
| smp_byte | input | 8 | Sampler run byte |
| smp_pkt_end | input | 1 | Sampler end-of-packet pulse |
| cfg_rx | output | 32 | Receive configuration register contents |
| cfg_sample | output | 32 | Sample configuration register contents |
| irq | output | 1 | Combined interrupt |

## Verification
The embedded properties check the following on every cycle: the count bound, the one-step shrink of the count on a pop, the count held steady when a byte is dropped, an overflow flag that only rises after a real drop, the data-available flag set after the count exceeds the level, an `irq` that stays low with every enable cleared, an empty queue one cycle after OFF, and no growth in HOLD. Other behaviours can only be shown by the bench scenarios: the byte order through the queue, the same-cycle pop and push on a full queue, which flags a clear write leaves alone, the set that wins over a clear in the same cycle, and register readback. The bench model also compares every register and `irq` on every cycle.

// File: rtl/ir_rx_pkg.sv
`timescale 1ns/1ps
package ir_rx_pkg;
    parameter int unsigned ADDR_W      = 6;
    parameter int unsigned REG_W       = 32;
    parameter int unsigned BYTE_W      = 8;
    parameter int unsigned LVL_W       = 4;
    parameter int unsigned CNT_FIELD_W = 6;

    localparam logic [ADDR_W-1:0] A_CTRL   = 6'h00;
    localparam logic [ADDR_W-1:0] A_RXCFG  = 6'h10;
    localparam logic [ADDR_W-1:0] A_DATA   = 6'h20;
    localparam logic [ADDR_W-1:0] A_IEN    = 6'h2C;
    localparam logic [ADDR_W-1:0] A_STAT   = 6'h30;
    localparam logic [ADDR_W-1:0] A_SMPCFG = 6'h34;

    // flag vector order inside the block: [0] overflow, [1] packet end, [2] available
    localparam int unsigned F_OVF = 0;
    localparam int unsigned F_PKT = 1;
    localparam int unsigned F_AVL = 2;

    typedef enum logic [1:0] {
        S_OFF  = 2'd0,
        S_HOLD = 2'd1,
        S_RUN  = 2'd2
    } rx_state_e;
endpackage

// File: rtl/ir_rx_fifo.sv
`timescale 1ns/1ps
module ir_rx_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned W     = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [W-1:0]     din_i,
    output logic [W-1:0]     dout_o,
    output logic [CNT_W-1:0] count_o,
    output logic             drop_o
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic             full, pop_ok, push_ok;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count_q == CNT_W'(DEPTH));
    assign pop_ok  = pop_i && (count_q != '0) && !flush_i;
    assign push_ok = push_i && !flush_i && (!full || pop_ok);
    assign drop_o  = push_i && !flush_i && full && !pop_ok;
    assign dout_o  = mem[rd_ptr_q];
    assign count_o = count_q;

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr_q] <= din_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            count_q  <= '0;
        end else if (flush_i) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (pop_ok)  rd_ptr_q <= step(rd_ptr_q);
            if (push_ok) wr_ptr_q <= step(wr_ptr_q);
            if (push_ok && !pop_ok)      count_q <= count_q + 1'b1;
            else if (pop_ok && !push_ok) count_q <= count_q - 1'b1;
        end
    end

    // R1
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));
    // R2
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && count_q != '0 && !push_i && !flush_i) |=> (count_q == $past(count_q) - 1'b1));
    // R6
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o |=> (count_q == $past(count_q)));
endmodule

// File: rtl/ir_rx_flags.sv
`timescale 1ns/1ps
module ir_rx_flags #(
    parameter int unsigned CNT_W = 5,
    parameter int unsigned LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drop_i,
    input  logic             pkt_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic [2:0]       ena_i,
    input  logic [2:0]       clr_i,
    output logic [2:0]       flags_o,
    output logic             irq_o
);
    import ir_rx_pkg::*;

    logic [2:0] flags_q, set_v;
    logic       above;

    assign above = int'(count_i) > int'(level_i);

    always_comb begin
        set_v        = '0;
        set_v[F_OVF] = drop_i;
        set_v[F_PKT] = pkt_i;
        set_v[F_AVL] = above;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= set_v | (flags_q & ~clr_i);
    end

    assign flags_o = flags_q;
    assign irq_o   = |(flags_q & ena_i);

    // R5
    avail_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        above |=> flags_q[F_AVL]);
    // R6
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[F_OVF]) |-> $past(drop_i));
    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_i == 3'b000) |-> !irq_o);
endmodule

// File: rtl/ir_rx_buffer.sv
`timescale 1ns/1ps
module ir_rx_buffer #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [5:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        smp_valid,
    input  logic [7:0]  smp_byte,
    input  logic        smp_pkt_end,
    output logic [31:0] cfg_rx,
    output logic [31:0] cfg_sample,
    output logic        irq
);
    import ir_rx_pkg::*;

    rx_state_e        state_q, state_d;
    logic             gen_q;
    logic [1:0]       mode_q;
    logic [2:0]       ien_q;
    logic [LVL_W-1:0] lvl_q;
    logic [REG_W-1:0] rxcfg_q, smpcfg_q;
    logic             accept, flush;
    logic             wr_ctrl, wr_stat, pop_req;
    logic [2:0]       clr, flags;
    logic [BYTE_W-1:0] head;
    logic [CNT_W-1:0] count;
    logic             drop;

    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign wr_stat = reg_wr && (reg_addr == A_STAT);
    assign pop_req = reg_rd && (reg_addr == A_DATA);
    assign clr     = {reg_wdata[4], reg_wdata[1], reg_wdata[0]} & {3{wr_stat}};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    // transitions: only a control write moves the machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OFF: begin
                if (wr_ctrl && reg_wdata[1]) state_d = reg_wdata[0] ? S_RUN : S_HOLD;
            end
            S_HOLD: begin
                if (wr_ctrl) state_d = !reg_wdata[1] ? S_OFF : (reg_wdata[0] ? S_RUN : S_HOLD);
            end
            S_RUN: begin
                if (wr_ctrl) state_d = !reg_wdata[1] ? S_OFF : (reg_wdata[0] ? S_RUN : S_HOLD);
            end
            default: state_d = S_OFF;
        endcase
    end

    // state outputs
    always_comb begin
        accept = 1'b0;
        flush  = 1'b0;
        unique case (state_q)
            S_OFF:   flush  = 1'b1;
            S_HOLD:  ;
            S_RUN:   accept = 1'b1;
            default: flush  = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q    <= 1'b0;
            mode_q   <= '0;
            ien_q    <= '0;
            lvl_q    <= '0;
            rxcfg_q  <= '0;
            smpcfg_q <= '0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                A_CTRL: begin
                    gen_q  <= reg_wdata[0];
                    mode_q <= reg_wdata[5:4];
                end
                A_IEN: begin
                    ien_q <= {reg_wdata[4], reg_wdata[1], reg_wdata[0]};
                    lvl_q <= reg_wdata[8 +: LVL_W];
                end
                A_RXCFG:  rxcfg_q  <= reg_wdata;
                A_SMPCFG: smpcfg_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    ir_rx_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (flush),
        .push_i  (smp_valid && accept),
        .pop_i   (pop_req),
        .din_i   (smp_byte),
        .dout_o  (head),
        .count_o (count),
        .drop_o  (drop)
    );

    ir_rx_flags #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .drop_i  (drop),
        .pkt_i   (smp_pkt_end && accept),
        .count_i (count),
        .level_i (lvl_q),
        .ena_i   (ien_q),
        .clr_i   (clr),
        .flags_o (flags),
        .irq_o   (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[0]   = gen_q;
                reg_rdata[1]   = (state_q != S_OFF);
                reg_rdata[5:4] = mode_q;
            end
            A_RXCFG:  reg_rdata = rxcfg_q;
            A_DATA:   if (count != '0) reg_rdata[BYTE_W-1:0] = head;
            A_IEN: begin
                reg_rdata[0]            = ien_q[F_OVF];
                reg_rdata[1]            = ien_q[F_PKT];
                reg_rdata[4]            = ien_q[F_AVL];
                reg_rdata[8 +: LVL_W]   = lvl_q;
            end
            A_STAT: begin
                reg_rdata[0]                = flags[F_OVF];
                reg_rdata[1]                = flags[F_PKT];
                reg_rdata[4]                = flags[F_AVL];
                reg_rdata[8 +: CNT_FIELD_W] = CNT_FIELD_W'(count);
            end
            A_SMPCFG: reg_rdata = smpcfg_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign cfg_rx     = rxcfg_q;
    assign cfg_sample = smpcfg_q;

    // R10
    off_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_OFF) |=> (count == '0));
    // R3
    hold_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HOLD) |=> (count <= $past(count)));
endmodule

// File: tb/ir_rx_buffer_test.sv
`timescale 1ns/1ps
module ir_rx_buffer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        smp_valid = 1'b0, smp_pkt_end = 1'b0;
    logic [7:0]  smp_byte = '0;
    logic [31:0] cfg_rx, cfg_sample;
    logic        irq;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ir_rx_buffer uut (.*);

    // behavioural reference model
    byte unsigned q[$];
    bit m_gen, m_rx, m_ovf, m_pkt, m_av, e_ovf, e_pkt, e_av;
    bit [1:0] m_mode;
    int m_lvl;
    logic [31:0] m_rxcfg, m_smpcfg;

    function automatic logic [31:0] model_read(input logic [5:0] a);
        logic [31:0] v = '0;
        case (a)
            6'h00: v = {26'd0, m_mode, 2'b00, m_rx, m_gen};
            6'h10: v = m_rxcfg;
            6'h20: v = (q.size() > 0) ? {24'd0, q[0]} : 32'd0;
            6'h2C: v = {20'd0, 4'(m_lvl), 3'd0, e_av, 2'd0, e_pkt, e_ovf};
            6'h30: v = {18'd0, 6'(q.size()), 3'd0, m_av, 2'd0, m_pkt, m_ovf};
            6'h34: v = m_smpcfg;
            default: v = '0;
        endcase
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_gen = 0; m_rx = 0; m_mode = 0; m_lvl = 0;
            m_ovf = 0; m_pkt = 0; m_av = 0; e_ovf = 0; e_pkt = 0; e_av = 0;
            m_rxcfg = 0; m_smpcfg = 0;
        end else begin
            automatic int cnt = q.size();
            automatic bit run = m_gen && m_rx;
            automatic bit off = !m_rx;
            automatic logic [7:0] c = (reg_wr && reg_addr == 6'h30) ? reg_wdata[7:0] : 8'h00;
            automatic bit pop = reg_rd && reg_addr == 6'h20 && cnt > 0 && !off;
            automatic bit push = smp_valid && run;
            automatic bit drop = push && cnt == 16 && !pop;
            m_av  = (cnt > m_lvl) || (m_av && !c[4]);
            m_ovf = drop || (m_ovf && !c[0]);
            m_pkt = (smp_pkt_end && run) || (m_pkt && !c[1]);
            if (off) q.delete();
            else begin
                if (pop) void'(q.pop_front());
                if (push && !drop) q.push_back(smp_byte);
            end
            if (reg_wr) case (reg_addr)
                6'h00: begin m_gen = reg_wdata[0]; m_rx = reg_wdata[1]; m_mode = reg_wdata[5:4]; end
                6'h2C: begin e_ovf = reg_wdata[0]; e_pkt = reg_wdata[1]; e_av = reg_wdata[4]; m_lvl = int'(reg_wdata[11:8]); end
                6'h10: m_rxcfg = reg_wdata;
                6'h34: m_smpcfg = reg_wdata;
                default: ;
            endcase
        end
    end

    // per-cycle comparison against the model
    always begin
        @(negedge clk);
        #1;
        if (rst_n && !done) begin
            automatic logic [31:0] e = model_read(reg_addr);
            automatic bit e_irq = (m_ovf && e_ovf) || (m_pkt && e_pkt) || (m_av && e_av);
            n_chk++;
            if (reg_rdata !== e) begin
                n_bad++;
                $display("FAIL R2/R11 cycle read addr %h: got %h expected %h", reg_addr, reg_rdata, e);
            end
            n_chk++;
            if (irq !== e_irq) begin
                n_bad++;
                $display("FAIL R9 cycle irq: got %b expected %b", irq, e_irq);
            end
            n_chk++;
            if (cfg_rx !== m_rxcfg || cfg_sample !== m_smpcfg) begin
                n_bad++;
                $display("FAIL R11 cfg outputs: got %h/%h expected %h/%h", cfg_rx, cfg_sample, m_rxcfg, m_smpcfg);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0; reg_wdata = 0;
    endtask

    task automatic peek(input string tag, input logic [5:0] a, input logic [31:0] mask, input logic [31:0] exp);
        @(negedge clk); reg_addr = a; #1;
        chk(tag, reg_rdata & mask, exp);
    endtask

    task automatic pop(input string tag, input logic [7:0] exp);
        @(negedge clk); reg_addr = 6'h20; reg_rd = 1; #1;
        chk(tag, reg_rdata, {24'd0, exp});
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk); smp_valid = 1; smp_byte = b;
        @(negedge clk); smp_valid = 0;
    endtask

    task automatic pkt();
        @(negedge clk); smp_pkt_end = 1;
        @(negedge clk); smp_pkt_end = 0;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // reset state
        peek("R11 ctrl after reset", 6'h00, 32'hFFFFFFFF, 32'h0);
        peek("R1 status after reset", 6'h30, 32'hFFFFFFFF, 32'h0);
        chk("R9 irq after reset", {31'd0, irq}, 32'd0);
        wr(6'h10, 32'h0000_0004);
        wr(6'h34, 32'h0000_1451);
        peek("R11 rx config", 6'h10, 32'hFFFFFFFF, 32'h4);
        peek("R11 sample config", 6'h34, 32'hFFFFFFFF, 32'h1451);
        chk("R11 cfg_sample port", cfg_sample, 32'h1451);
        wr(6'h08, 32'hFFFF_FFFF);
        peek("R11 unmapped address", 6'h08, 32'hFFFFFFFF, 32'h0);

        // RUN, ordering
        wr(6'h00, 32'h33);
        peek("R11 ctrl readback", 6'h00, 32'hFFFFFFFF, 32'h33);
        push(8'h81); push(8'h05); push(8'h7F);
        peek("R1 count three", 6'h30, 32'hFFFFFFFF, 32'h0310);
        chk("R9 irq masked", {31'd0, irq}, 32'd0);
        pop("R2 first byte", 8'h81);
        pop("R2 second byte", 8'h05);
        pop("R2 third byte", 8'h7F);
        peek("R2 empty reads zero", 6'h20, 32'hFFFFFFFF, 32'h0);
        pop("R2 pop of empty", 8'h00);
        wr(6'h30, 32'hFF);
        peek("R8 clear all", 6'h30, 32'hFFFFFFFF, 32'h0);

        // HOLD
        wr(6'h00, 32'h32);
        push(8'h11);
        peek("R3 hold ignores byte", 6'h30, 32'h3F00, 32'h0);
        wr(6'h00, 32'h33);
        push(8'h22);
        wr(6'h00, 32'h32);
        peek("R3 hold keeps byte", 6'h30, 32'h3F00, 32'h0100);
        wr(6'h00, 32'h33);
        pop("R3 kept byte intact", 8'h22);
        wr(6'h30, 32'hFF);

        // level trigger
        wr(6'h2C, 32'h0310);
        peek("R4 enable readback", 6'h2C, 32'hFFFFFFFF, 32'h0310);
        for (int i = 1; i <= 4; i++) push(8'(i));
        tick();
        peek("R5 avail above level", 6'h30, 32'hFFFFFFFF, 32'h0410);
        chk("R9 irq on avail", {31'd0, irq}, 32'd1);
        wr(6'h30, 32'h10);
        peek("R5 clear while above", 6'h30, 32'hFFFFFFFF, 32'h0410);
        pop("R2 level drain", 8'h01);
        wr(6'h30, 32'h10);
        peek("R8 clear at level", 6'h30, 32'hFFFFFFFF, 32'h0300);
        chk("R9 irq drops", {31'd0, irq}, 32'd0);
        pop("R2 drain b", 8'h02); pop("R2 drain c", 8'h03); pop("R2 drain d", 8'h04);
        wr(6'h30, 32'hFF);

        // overflow
        wr(6'h2C, 32'h0001);
        for (int i = 0; i < 18; i++) push(8'(8'h40 + i));
        peek("R6 full with overflow", 6'h30, 32'hFFFFFFFF, 32'h1011);
        chk("R9 irq on overflow", {31'd0, irq}, 32'd1);
        wr(6'h30, 32'h01);
        peek("R8 overflow cleared", 6'h30, 32'hFFFFFFFF, 32'h1010);
        @(negedge clk); reg_addr = 6'h20; reg_rd = 1; smp_valid = 1; smp_byte = 8'h99;
        @(negedge clk); reg_rd = 0; smp_valid = 0;
        peek("R6 pop and push when full", 6'h30, 32'hFFFFFFFF, 32'h1010);
        for (int i = 1; i < 16; i++) pop("R6 order after full", 8'(8'h40 + i));
        pop("R6 late byte last", 8'h99);

        // packet end
        wr(6'h30, 32'hFF);
        wr(6'h2C, 32'h0002);
        pkt();
        peek("R7 packet end flag", 6'h30, 32'hFFFFFFFF, 32'h0002);
        chk("R9 irq on packet end", {31'd0, irq}, 32'd1);
        wr(6'h30, 32'h01);
        peek("R8 other flag kept", 6'h30, 32'hFFFFFFFF, 32'h0002);
        wr(6'h30, 32'hFF);
        peek("R8 all cleared", 6'h30, 32'hFFFFFFFF, 32'h0);
        @(negedge clk); reg_wr = 1; reg_addr = 6'h30; reg_wdata = 32'h02; smp_pkt_end = 1;
        @(negedge clk); reg_wr = 0; smp_pkt_end = 0;
        peek("R8 set beats clear", 6'h30, 32'hFFFFFFFF, 32'h0002);
        wr(6'h30, 32'hFF);
        wr(6'h00, 32'h32);
        pkt();
        peek("R7 no packet end in hold", 6'h30, 32'hFFFFFFFF, 32'h0);

        // flush
        wr(6'h00, 32'h33);
        push(8'hA1); push(8'hA2); push(8'hA3);
        wr(6'h00, 32'h31);
        tick();
        peek("R10 flushed count", 6'h30, 32'h3F00, 32'h0);
        peek("R10 ctrl shows off", 6'h00, 32'hFFFFFFFF, 32'h31);
        push(8'hB0);
        peek("R10 off takes nothing", 6'h20, 32'hFFFFFFFF, 32'h0);

        repeat (2) tick();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule